// File: doc/BRIEF.md
# Indirect register access port

This block is a byte-wide bus slave that gives a processor access to many internal registers through a two-location window. The processor first writes a register number to the command location. It then reads or writes that register through the data location. When a register is wider than one byte, successive data accesses move through its bytes, least significant byte first. A data access past the last byte of the selected register has no effect.

The same command location, when read, returns the interrupt status byte. This byte collects event pulses from the functions that sit behind the registers. The read clears the byte in the same access. An event that arrives during that read is kept for the next read. The interrupt line is the OR of the pending bits. The global mode register can hold the line low.

Inside the block are the following registers:
- a small byte RAM that holds the multiplexer control registers, the gain registers and the mode registers;
- a dedicated mode/initialisation register;
- a dedicated transfer-control register whose bits feed the interrupt logic.

Top module: `ind_reg_port`

## Requirements
- R1: Address decode:
  - A write to offset 0 loads the register number.
  - Offset 1 is the data location for both reads and writes.
  - Writes to any other offset change nothing.
  - Reads of any other offset return 0x00.
  - When the write and read strobes are both high, the write is performed and the read is not.
- R2: Every read strobe (without a write strobe) produces exactly one cycle of `bus_rvalid` on the following clock. `bus_rdata` carries the result during that cycle.
- R3: A read of offset 0 returns the pending interrupt byte and clears it. The bit positions are:
  - bit0: D transmit threshold
  - bit1: D receive threshold
  - bit2: D packet status
  - bit3: D error
  - bit4: B transfer
  - bit5: line status
  - bit6: D buffer status
  - bit7: multiframe
- R4: An event that arrives in the same cycle as an interrupt-byte read is not returned by that read. It stays pending and is returned by the next read.
- R5: The registers and their widths are:
  - Two bytes wide: 0x63, 0x64, 0x65 and 0x66. They take two consecutive data accesses after one command write, low byte first.
  - One byte wide, one data access each: 0x21, 0x41, 0x42, 0x43, 0x44, 0x69 and 0x6A.
  - Every register reads back the value that was written to it.
- R6: A data access past the last byte of the selected register is ignored on write and reads 0x00. Every register number not listed in R5 has zero bytes.
- R7: Writing a register number to offset 0 resets the byte index to 0, even when the number is the same as before.
- R8: Register 0x21 is the mode register and resets to 0x00 (idle). The interrupt line may be asserted only when bits[1:0] are nonzero and bit2 (the mask) is clear. For example, 0x01 is active with interrupts; 0x05 is active with interrupts masked.
- R9: `irq` is the OR of the pending bits, gated as in R8:
  - An event sampled at clock edge N raises `irq` after edge N+1.
  - An interrupt-byte read sampled at edge M lowers `irq` after edge M+1.
- R10: A bit4 event becomes pending only while bit3 of register 0x44 is set. Otherwise it is dropped.
- R11: After reset:
  - `irq` and `bus_rvalid` are low.
  - No bits are pending.
  - Registers 0x21 and 0x44 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Direct window offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read result strobe, one cycle after bus_rd |
| evt_in | input | EVT_W | Event pulses from the sources behind the port |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed delay after the edge that samples its stimulus:
- Read data appears one edge after the read strobe is sampled.
- A pending bit is set on the edge that samples the event.
- `irq` follows one edge after the pending bit changes. It therefore rises or falls two edges after the event or the clearing read.

The driver changes the inputs only on falling edges. For each read, the driver queues the expected byte on the falling edge where it raises the read strobe. A monitor pops and compares that byte on the next falling edge that shows `bus_rvalid`. Checks of `irq` are made on the falling edge after the second rising edge that follows the stimulus. The case where an event coincides with the clearing read is driven within a single cycle.

// File: rtl/irp_pkg.sv
`timescale 1ns/1ps
package irp_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 2;
  localparam int IDX_W     = $clog2(MAX_BYTES + 1);
  localparam int NSLOT     = 9;
  localparam int SLOT_W    = 4;

  localparam logic [7:0] NUM_MODE  = 8'h21;
  localparam logic [7:0] NUM_XCTL  = 8'h44;
  localparam int MODE_MASK_BIT     = 2;
  localparam int XCTL_BEN_BIT      = 3;
  localparam int EVT_BXFER_BIT     = 4;

  typedef enum logic [1:0] {RK_NONE, RK_RAM, RK_MODE, RK_XCTL} rkind_e;

  typedef struct packed {
    rkind_e             kind;
    logic [SLOT_W-1:0]  slot;
    logic [IDX_W-1:0]   nbytes;
  } rinfo_t;

  function automatic rinfo_t lookup(input logic [7:0] num);
    rinfo_t r;
    r = '{kind: RK_NONE, slot: '0, nbytes: '0};
    case (num)
      NUM_MODE: r = '{kind: RK_MODE, slot: '0, nbytes: IDX_W'(1)};
      NUM_XCTL: r = '{kind: RK_XCTL, slot: '0, nbytes: IDX_W'(1)};
      8'h41:    r = '{kind: RK_RAM, slot: SLOT_W'(0), nbytes: IDX_W'(1)};
      8'h42:    r = '{kind: RK_RAM, slot: SLOT_W'(1), nbytes: IDX_W'(1)};
      8'h43:    r = '{kind: RK_RAM, slot: SLOT_W'(2), nbytes: IDX_W'(1)};
      8'h63:    r = '{kind: RK_RAM, slot: SLOT_W'(3), nbytes: IDX_W'(2)};
      8'h64:    r = '{kind: RK_RAM, slot: SLOT_W'(4), nbytes: IDX_W'(2)};
      8'h65:    r = '{kind: RK_RAM, slot: SLOT_W'(5), nbytes: IDX_W'(2)};
      8'h66:    r = '{kind: RK_RAM, slot: SLOT_W'(6), nbytes: IDX_W'(2)};
      8'h69:    r = '{kind: RK_RAM, slot: SLOT_W'(7), nbytes: IDX_W'(1)};
      8'h6A:    r = '{kind: RK_RAM, slot: SLOT_W'(8), nbytes: IDX_W'(1)};
      default:  r = '{kind: RK_NONE, slot: '0, nbytes: '0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irp_seq.sv
`timescale 1ns/1ps
// Direct window decode, register-number latch and byte index sequencing.
module irp_seq
  import irp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output rinfo_t              info,
  output logic [IDX_W-1:0]    idx,
  output logic                in_range,
  output logic                dat_wr,
  output logic                dat_rd,
  output logic                ir_rd,
  output logic                any_rd
);
  logic [7:0]       num_q;
  logic [IDX_W-1:0] idx_q;
  logic             at_cmd, at_dat, cmd_wr;

  always_comb begin
    at_cmd   = (addr == ADDR_W'(0));
    at_dat   = (addr == ADDR_W'(1));
    any_rd   = rd_en & ~wr_en;
    cmd_wr   = wr_en & at_cmd;
    dat_wr   = wr_en & at_dat;
    dat_rd   = any_rd & at_dat;
    ir_rd    = any_rd & at_cmd;
    info     = lookup(num_q);
    idx      = idx_q;
    in_range = (idx_q < info.nbytes);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
      idx_q <= '0;
    end else if (cmd_wr) begin
      num_q <= wdata;
      idx_q <= '0;
    end else if ((dat_wr | dat_rd) && in_range) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/irp_regs.sv
`timescale 1ns/1ps
// Indirect register storage: inferable byte RAM plus two dedicated registers.
module irp_regs
  import irp_pkg::*;
#(
  parameter int SLOTS = NSLOT,
  parameter int BYTES = MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  rinfo_t            info,
  input  logic [IDX_W-1:0]  idx,
  input  logic              in_range,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              irq_allow,
  output logic              bxfer_en
);
  localparam int DEPTH = SLOTS * BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] ram_q, ded_q, mode_q, xctl_q;
  logic [AW-1:0]     ram_a;
  logic              ram_we, ok_q, from_ram_q;

  always_comb begin
    ram_a  = AW'(info.slot) * AW'(BYTES) + AW'(idx);
    ram_we = dat_wr & in_range & (info.kind == RK_RAM);
  end

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_a] <= wdata;
    ram_q <= mem[ram_a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      xctl_q     <= '0;
      ok_q       <= 1'b0;
      from_ram_q <= 1'b0;
      ded_q      <= '0;
    end else begin
      if (dat_wr && in_range && info.kind == RK_MODE) mode_q <= wdata;
      if (dat_wr && in_range && info.kind == RK_XCTL) xctl_q <= wdata;
      ok_q       <= dat_rd & in_range;
      from_ram_q <= (info.kind == RK_RAM);
      ded_q      <= (info.kind == RK_MODE) ? mode_q : xctl_q;
    end
  end

  always_comb begin
    rd_byte   = !ok_q ? '0 : (from_ram_q ? ram_q : ded_q);
    irq_allow = (mode_q[1:0] != 2'b00) & ~mode_q[MODE_MASK_BIT];
    bxfer_en  = xctl_q[XCTL_BEN_BIT];
  end
endmodule

// File: rtl/irp_intc.sv
`timescale 1ns/1ps
// Interrupt collection, clear-on-read and gated request output.
module irp_intc
  import irp_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt,
  input  logic             ir_rd,
  input  logic             bxfer_en,
  input  logic             irq_allow,
  output logic [EVT_W-1:0] pend,
  output logic             irq
);
  logic [EVT_W-1:0] pend_q, accept;

  always_comb begin
    accept = evt;
    accept[EVT_BXFER_BIT] = evt[EVT_BXFER_BIT] & bxfer_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= (ir_rd ? '0 : pend_q) | accept;
      irq    <= (|pend_q) & irq_allow;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/ind_reg_port.sv
`timescale 1ns/1ps
module ind_reg_port
  import irp_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              irq
);
  rinfo_t            seq_info;
  logic [IDX_W-1:0]  seq_idx;
  logic              in_range, dat_wr, dat_rd, ir_rd, any_rd;
  logic [7:0]        rd_byte;
  logic              irq_allow, bxfer_en;
  logic [EVT_W-1:0]  pend;
  logic [7:0]        ir_snap_q;
  logic              src_ir_q, src_dat_q;

  irp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .info(seq_info), .idx(seq_idx), .in_range(in_range),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .ir_rd(ir_rd), .any_rd(any_rd)
  );

  irp_regs u_regs (
    .clk(clk), .rst(rst), .info(seq_info), .idx(seq_idx), .in_range(in_range),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wdata(bus_wdata), .rd_byte(rd_byte),
    .irq_allow(irq_allow), .bxfer_en(bxfer_en)
  );

  irp_intc #(.EVT_W(EVT_W)) u_intc (
    .clk(clk), .rst(rst), .evt(evt_in), .ir_rd(ir_rd), .bxfer_en(bxfer_en),
    .irq_allow(irq_allow), .pend(pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      src_ir_q   <= 1'b0;
      src_dat_q  <= 1'b0;
      ir_snap_q  <= '0;
    end else begin
      bus_rvalid <= any_rd;
      src_ir_q   <= ir_rd;
      src_dat_q  <= dat_rd;
      ir_snap_q  <= 8'(pend);
    end
  end

  assign bus_rdata = src_ir_q ? ir_snap_q : (src_dat_q ? rd_byte : 8'h00);
endmodule

// File: rtl/irp_chk.sv
`timescale 1ns/1ps
module irp_chk
  import irp_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int EVT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              bus_rvalid,
  input logic [EVT_W-1:0]  evt_in,
  input logic              irq,
  input logic [EVT_W-1:0]  pend,
  input logic              irq_allow,
  input logic              bxfer_en,
  input rinfo_t            seq_info,
  input logic [IDX_W-1:0]  seq_idx
);
  localparam logic [EVT_W-1:0] UNGATED = ~(EVT_W'(1) << EVT_BXFER_BIT);

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> bus_rvalid);

  assert_rvalid_only_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> !bus_rvalid);

  assert_ir_returns_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(0)) |=> (bus_rdata == 8'($past(pend))));

  assert_ir_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(0) && evt_in == '0) |=> (pend == '0));

  assert_event_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (|(evt_in & UNGATED)) |=> ((pend & $past(evt_in & UNGATED)) == $past(evt_in & UNGATED)));

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (rst)
    seq_idx <= seq_info.nbytes);

  assert_mask_holds_irq_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_allow |=> !irq);

  assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|pend));

  assert_bxfer_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (!bxfer_en && !pend[EVT_BXFER_BIT] && !(bus_rd && !bus_wr && bus_addr == ADDR_W'(0)))
      |=> !pend[EVT_BXFER_BIT]);
endmodule

bind ind_reg_port irp_chk #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .evt_in(evt_in), .irq(irq),
  .pend(pend), .irq_allow(irq_allow), .bxfer_en(bxfer_en),
  .seq_info(seq_info), .seq_idx(seq_idx)
);

// File: tb/tb_ind_reg_port.sv
`timescale 1ns/1ps
module tb_ind_reg_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, evt = '0;
  logic [7:0] rdata;
  logic       rvalid, irq;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  ind_reg_port dut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .evt_in(evt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per read result.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && rvalid === 1'b1) begin
      if (expq.size() == 0) chk("R2 unexpected rvalid", 8'h01, 8'h00);
      else begin
        e = expq.pop_front();
        chk(e.tag, rdata, e.v);
      end
    end
  end

  task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd = 1'b1; expq.push_back('{exp, tag});
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] num, input logic [7:0] d);
    wr_b(3'd0, num);
    wr_b(3'd1, d);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 irq after reset", {7'd0, irq}, 8'h00);
    chk("R11 rvalid after reset", {7'd0, rvalid}, 8'h00);
    rd_b(3'd0, 8'h00, "R11 pending after reset");
    wr_b(3'd0, 8'h21); rd_b(3'd1, 8'h00, "R11 mode reg after reset");
    wr_b(3'd0, 8'h44); rd_b(3'd1, 8'h00, "R11 xfer ctl after reset");

    // R9 with R8 idle: event pends but irq stays low
    pulse(8'h01); idle(1);
    chk("R8 idle mode holds irq low", {7'd0, irq}, 8'h00);
    rd_b(3'd0, 8'h01, "R3 pending while idle");

    // R8 active, R5 one-byte readback
    setreg(8'h21, 8'h01);
    wr_b(3'd0, 8'h21); rd_b(3'd1, 8'h01, "R5 mode reg readback");

    // R9 irq rise and fall
    pulse(8'h05); idle(1);
    chk("R9 irq raised", {7'd0, irq}, 8'h01);
    rd_b(3'd0, 8'h05, "R3 bits 0 and 2");
    idle(1);
    chk("R9 irq lowered after read", {7'd0, irq}, 8'h00);
    rd_b(3'd0, 8'h00, "R3 cleared by read");

    // R4 simultaneous event and clearing read
    pulse(8'h02);
    @(negedge clk); addr = 3'd0; rd = 1'b1; evt = 8'h08;
    expq.push_back('{8'h02, "R4 read returns old pending"});
    @(negedge clk); rd = 1'b0; evt = '0;
    rd_b(3'd0, 8'h08, "R4 coincident event kept");

    // R10 B transfer gating
    pulse(8'h10);
    rd_b(3'd0, 8'h00, "R10 bit4 dropped when disabled");
    setreg(8'h44, 8'h08);
    pulse(8'h90);
    rd_b(3'd0, 8'h90, "R10 bit4 accepted when enabled");
    wr_b(3'd0, 8'h44); rd_b(3'd1, 8'h08, "R5 xfer ctl readback");

    // R8 mask bit
    setreg(8'h21, 8'h05);
    pulse(8'h40); idle(2);
    chk("R8 masked irq low", {7'd0, irq}, 8'h00);
    setreg(8'h21, 8'h01); idle(1);
    chk("R8 unmasked irq high", {7'd0, irq}, 8'h01);
    rd_b(3'd0, 8'h40, "R3 bit6 pending");

    // R5 / R6 two-byte register
    wr_b(3'd0, 8'h63); wr_b(3'd1, 8'h34); wr_b(3'd1, 8'h12); wr_b(3'd1, 8'hAA);
    setreg(8'h66, 8'hCD); wr_b(3'd1, 8'hAB);
    wr_b(3'd0, 8'h63);
    rd_b(3'd1, 8'h34, "R5 low byte first");
    rd_b(3'd1, 8'h12, "R5 high byte second");
    rd_b(3'd1, 8'h00, "R6 read past last byte");
    wr_b(3'd0, 8'h66);
    rd_b(3'd1, 8'hCD, "R5 second word low");
    // R7 re-command restarts at byte 0
    wr_b(3'd0, 8'h66);
    rd_b(3'd1, 8'hCD, "R7 index reset by command");
    rd_b(3'd1, 8'hAB, "R5 second word high");

    // R5 / R6 one-byte register, extra write ignored
    setreg(8'h69, 8'h5A); wr_b(3'd1, 8'h77);
    wr_b(3'd0, 8'h69);
    rd_b(3'd1, 8'h5A, "R6 extra write ignored");
    rd_b(3'd1, 8'h00, "R6 one-byte register past end");

    // R6 unknown register number
    setreg(8'h50, 8'h11);
    wr_b(3'd0, 8'h50);
    rd_b(3'd1, 8'h00, "R6 unknown register reads zero");

    // R1 other offsets
    wr_b(3'd0, 8'h69);
    wr_b(3'd2, 8'h63);
    rd_b(3'd1, 8'h5A, "R1 write to offset 2 ignored");
    rd_b(3'd3, 8'h00, "R1 read of offset 3 is zero");

    // R1 simultaneous strobes: write wins, no read result
    @(negedge clk); addr = 3'd0; wdata = 8'h42; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    wr_b(3'd1, 8'h9C);
    wr_b(3'd0, 8'h42);
    rd_b(3'd1, 8'h9C, "R1 write taken when both strobes high");

    idle(3);
    chk("R2 all reads answered", 8'(expq.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule